// File: doc/BRIEF.md
# Fractional Pulse-Swallow Feedback Divider

This block divides a VCO-rate clock for the feedback path of a fractional-N synthesizer. A dual-modulus prescaler and its swallow and programmable counters are modelled as one down-counter. Each division cycle lasts P·N + A input clocks. P is one of two prescaler base ratios, N is the programmable count and A is the swallow count. A small fractional accumulator adds an increment F modulo Q at the start of every division cycle. Q is switchable between 8 and 5. When the accumulator wraps, the cycle that is starting is stretched by one input clock. Over Q cycles the average period is therefore P·N + A + F/Q clocks.

New settings are written into a pending (shadow) register with a one-clock load strobe. The divider takes them only at the boundary between two division cycles, so a running cycle is never cut short or stretched by a write. The block also flags a pending setting that breaks the range rules.

Top module: `frac_fb_divider`

## Requirements
- R1: While `rst_ni` is low at a clock edge (synchronous reset), the counter, the accumulator and the started flag are cleared. The pending setting returns to N=34, A=0, F=0, `q_sel_i`=1, `p_sel_i`=0. While in reset, `div_o` and `cfg_bad_o` are low.
- R2: `div_o` is a pulse one input clock wide. The first pulse appears in the cycle after the R-th rising edge counted from the first edge with `rst_ni` high, where R is the ratio in force. After that, the pulse-to-pulse spacing equals the ratio of each division cycle. The ratio is P·N + A, plus one when the accumulator carries.
- R3: `p_sel_i`=0 selects base ratio P=32 and `p_sel_i`=1 selects P=64. Both values are parameters.
- R4: At the start of each division cycle, the accumulator adds F to its value. If the sum reaches Q, it subtracts Q and that starting cycle lasts one extra clock.
- R5: `q_sel_i`=1 gives modulus Q=8 and `q_sel_i`=0 gives Q=5.
- R6: For a valid setting held over Q consecutive cycles, with the accumulator starting at zero, the total length of those cycles is Q·(P·N + A) + F clocks.
- R7: `load_i` high at an edge captures the inputs into the pending register. The pending value drives the first division cycle that starts after that edge. A cycle already running keeps its ratio, and the pending register keeps its value while `load_i` is low.
- R8: When a cycle starts with a modulus different from the previous cycle, the accumulator restarts at F and that cycle has no extra clock.
- R9: `cfg_bad_o` is high when the pending setting has N < 34, A ≥ N − 2, or F ≥ Q. It is valid from the clock after the load edge. An invalid setting still divides by the formula of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | VCO-rate input clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-clock strobe capturing the setting inputs |
| n_i | input | 10 | Programmable count N |
| a_i | input | 5 | Swallow count A |
| f_i | input | 4 | Fractional increment F |
| q_sel_i | input | 1 | Modulus select: 1 gives Q=8, 0 gives Q=5 |
| p_sel_i | input | 1 | Base ratio select: 0 gives P=32, 1 gives P=64 |
| div_o | output | 1 | Divided output pulse, one clock wide |
| cfg_bad_o | output | 1 | Pending setting breaks a range rule |

## Verification
The range flag is due one edge after the load edge, and the bench samples it on the falling edge that follows. A loaded setting first shows up in the length of the next division cycle, one full cycle after the load. The bench therefore loads only inside a running cycle, at least one edge after a boundary, and queues the expected lengths from that cycle onward. The monitor counts rising edges with reset released and measures each pulse against that count. It pops one expected length per pulse, so every stretch, modulus restart and ratio change is compared against the exact cycle in which it is due.

// File: rtl/frac_div_pkg.sv
// Shared widths, modulus constants and the setting record for the
// fractional feedback divider. Assumes moduli fit in F_W+1 bits.
package frac_div_pkg;
    parameter int N_W  = 10;
    parameter int A_W  = 5;
    parameter int F_W  = 4;
    parameter int Q_HI = 8;
    parameter int Q_LO = 5;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic [F_W-1:0] f;
        logic           q_sel;
        logic           p_sel;
    } div_cfg_t;
endpackage

// File: rtl/frac_cfg_shadow.sv
// Pending setting register with range check. Captures the setting on
// load_i; the divider consumes it only at cycle boundaries. Assumes the
// reset default is a valid setting.
module frac_cfg_shadow
    import frac_div_pkg::*;
#(
    parameter int N_MIN = 34
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     load_i,
    input  div_cfg_t cfg_i,
    output div_cfg_t pend_o,
    output logic     bad_o
);
    localparam int CW = N_W + 1;

    logic [F_W:0] mod_val;
    logic         n_low, a_high, f_high;

    // capture the setting on the load strobe, default on reset
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_o.n     <= N_W'(N_MIN);
            pend_o.a     <= '0;
            pend_o.f     <= '0;
            pend_o.q_sel <= 1'b1;
            pend_o.p_sel <= 1'b0;
        end else if (load_i) begin
            pend_o <= cfg_i;
        end
    end

    // range rules on the pending setting
    always_comb begin
        mod_val = pend_o.q_sel ? (F_W+1)'(Q_HI) : (F_W+1)'(Q_LO);
        n_low   = pend_o.n < N_W'(N_MIN);
        a_high  = (CW'(pend_o.a) + CW'(2)) >= CW'(pend_o.n);
        f_high  = {1'b0, pend_o.f} >= mod_val;
        bad_o   = n_low || a_high || f_high;
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(pend_o));
endmodule

// File: rtl/frac_accum.sv
// Fractional accumulator. Steps once per division cycle (adv_i), adding
// f_i modulo the selected modulus; carry_o stretches the starting cycle.
// A modulus change restarts the phase at f_i without carry. Assumes
// f_i is below the modulus for exact averaging.
module frac_accum
    import frac_div_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           adv_i,
    input  logic [F_W-1:0] f_i,
    input  logic           q_sel_i,
    output logic           carry_o
);
    logic [F_W:0] acc_q;
    logic [F_W:0] sum;
    logic [F_W:0] mod_val;
    logic         qs_q;
    logic         restart;

    // next-sum, carry and restart decision
    always_comb begin
        mod_val = q_sel_i ? (F_W+1)'(Q_HI) : (F_W+1)'(Q_LO);
        sum     = acc_q + {1'b0, f_i};
        restart = q_sel_i != qs_q;
        carry_o = !restart && (sum >= mod_val);
    end

    // phase and last-modulus state, advanced at boundaries
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
            qs_q  <= 1'b1;
        end else if (adv_i) begin
            qs_q  <= q_sel_i;
            acc_q <= restart ? {1'b0, f_i} : (carry_o ? sum - mod_val : sum);
        end
    end

    // R4
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(acc_q));

    // R8
    restart_nocarry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && restart) |-> !carry_o);
endmodule

// File: rtl/frac_cycle_cnt.sv
// Division-cycle counter. Loads ratio_i-1 at each boundary and counts
// down to zero; zero marks the boundary. The pulse is held off for the
// unprimed boundary right after reset. Assumes ratio_i >= 2.
module frac_cycle_cnt #(
    parameter int CNT_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             bnd_o,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // boundary and output pulse decode
    always_comb begin
        bnd_o   = cnt_q == '0;
        pulse_o = bnd_o && primed_q;
    end

    // reload at boundary, else count down
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            cnt_q    <= bnd_o ? ratio_i - CNT_W'(1) : cnt_q - CNT_W'(1);
        end
    end

    // R2
    reload_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bnd_o |=> cnt_q != '0);
endmodule

// File: rtl/frac_fb_divider.sv
// Top of the fractional pulse-swallow feedback divider. Forms the cycle
// ratio P*N + A + carry from the pending setting and the accumulator,
// and feeds it to the cycle counter. Assumes P_HI*N fits CNT_W bits.
module frac_fb_divider
    import frac_div_pkg::*;
#(
    parameter int P_LO  = 32,
    parameter int P_HI  = 64,
    parameter int N_MIN = 34
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic [N_W-1:0] n_i,
    input  logic [A_W-1:0] a_i,
    input  logic [F_W-1:0] f_i,
    input  logic           q_sel_i,
    input  logic           p_sel_i,
    output logic           div_o,
    output logic           cfg_bad_o
);
    localparam int CNT_W = $clog2(P_HI * (2 ** N_W) + (2 ** A_W) + 1);

    div_cfg_t         cfg_in;
    div_cfg_t         pend;
    logic             carry;
    logic             bnd;
    logic [CNT_W-1:0] p_val;
    logic [CNT_W-1:0] ratio;

    // gather the setting inputs into one record
    always_comb begin
        cfg_in.n     = n_i;
        cfg_in.a     = a_i;
        cfg_in.f     = f_i;
        cfg_in.q_sel = q_sel_i;
        cfg_in.p_sel = p_sel_i;
    end

    frac_cfg_shadow #(.N_MIN(N_MIN)) shadow_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_i),
        .cfg_i  (cfg_in),
        .pend_o (pend),
        .bad_o  (cfg_bad_o)
    );

    frac_accum accum_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (bnd),
        .f_i     (pend.f),
        .q_sel_i (pend.q_sel),
        .carry_o (carry)
    );

    // ratio of the cycle starting at the next boundary
    always_comb begin
        p_val = pend.p_sel ? CNT_W'(P_HI) : CNT_W'(P_LO);
        ratio = p_val * CNT_W'(pend.n) + CNT_W'(pend.a) + CNT_W'(carry);
    end

    frac_cycle_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ratio_i (ratio),
        .bnd_o   (bnd),
        .pulse_o (div_o)
    );

    // R2
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_o |=> !div_o);
endmodule

// File: tb/frac_fb_divider_tb_top.sv
module frac_fb_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [9:0] n_in = 10'd34;
    logic [4:0] a_in = '0;
    logic [3:0] f_in = '0;
    logic       qs_in = 1'b1;
    logic       ps_in = 1'b0;
    logic       div;
    logic       bad;

    int checks = 0;
    int fails = 0;
    int edges = 0;
    int last_edge = 0;
    int pulses_seen = 0;
    int pushed = 0;
    int m_acc = 0;
    int m_qs = 1;
    bit done = 1'b0;
    int    exp_per[$];
    string exp_tag[$];
    int    obs[$];

    always #2 clk = ~clk;

    frac_fb_divider dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load),
        .n_i(n_in), .a_i(a_in), .f_i(f_in), .q_sel_i(qs_in), .p_sel_i(ps_in),
        .div_o(div), .cfg_bad_o(bad)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // bench model of one division cycle (R3, R4, R5, R8)
    function automatic int step(input int n, input int a, input int f,
                                input int qs, input int ps);
        int q = qs ? 8 : 5;
        int p = ps ? 64 : 32;
        int c = 0;
        if (qs != m_qs) begin
            m_acc = f;
            m_qs  = qs;
        end else begin
            m_acc += f;
            if (m_acc >= q) begin
                m_acc -= q;
                c = 1;
            end
        end
        return p * n + a + c;
    endfunction

    // driver: load inside a running cycle, queue the cycles it governs
    task automatic apply(input int n, input int a, input int f, input int qs,
                         input int ps, input int k, input int exp_bad,
                         input string tag);
        wait (pulses_seen == pushed - 1);
        @(posedge clk); #1;
        n_in = 10'(n); a_in = 5'(a); f_in = 4'(f); qs_in = qs[0]; ps_in = ps[0];
        load = 1'b1;
        @(posedge clk); #1;
        load = 1'b0;
        @(negedge clk);
        chk("R9", int'(bad), exp_bad);
        for (int i = 0; i < k; i++) begin
            exp_per.push_back(step(n, a, f, qs, ps));
            exp_tag.push_back(tag);
        end
        pushed += k;
    endtask

    // edge counter since reset release
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    // monitor: pop and compare one expected length per pulse
    logic prev_div = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (div && prev_div) chk("R2 width", 2, 1);
            if (div) begin
                if (exp_per.size() == 0) begin
                    chk("R2 unexpected pulse", edges - last_edge, 0);
                end else begin
                    chk(exp_tag.pop_front(), edges - last_edge, exp_per.pop_front());
                end
                obs.push_back(edges - last_edge);
                last_edge = edges;
                pulses_seen++;
            end
        end
        prev_div = div;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int sum;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 div", int'(div), 0);
        chk("R1 bad", int'(bad), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // default setting rules the first cycle; R7 load below must not touch it
        exp_per.push_back(step(34, 0, 0, 1, 0));
        exp_tag.push_back("R7 first cycle");
        pushed = 1;
        apply(40, 7, 3, 1, 0, 8, 0, "R4");
        apply(34, 31, 2, 0, 0, 5, 0, "R5");
        apply(36, 0, 7, 1, 1, 8, 0, "R3");
        apply(33, 31, 0, 1, 0, 2, 1, "R9 div");
        apply(40, 3, 5, 0, 0, 0, 1, "R9");
        apply(50, 12, 4, 0, 0, 5, 0, "R8");
        wait (pulses_seen == pushed);
        repeat (2) @(negedge clk);
        // R6: cycles 2..9 ran F=3 over Q=8 starting from zero phase
        sum = 0;
        for (int i = 1; i <= 8; i++) sum += obs[i];
        chk("R6", sum, 8 * (32 * 40 + 7) + 3);
        report();
    end
endmodule